// File: doc/BRIEF.md
# I2C Register Target

This block is an I2C target that answers one 7-bit device address, supplied on a port, and holds a small bank of byte registers (16 by default). It takes the raw SCL and SDA lines and passes each through a synchronizer. It watches for edges and bus conditions in its own system clock. It never drives the bus high. It only asserts an open-drain enable that pulls SDA low, for acknowledges and for zero data bits.

A bus master writes by sending the device address with the direction bit clear, then a register index, then any number of data bytes. To read, the master sets the index the same way, issues a repeated START and sends the address again with the direction bit set. The index is kept across the repeated START, so a combined write-then-read returns the selected register. A parameter switches the block to a single-register form, in which data follows the address directly. Local logic can read and write the same registers through a simple host port.

Top module: `i2c_reg_target`

## Requirements
- R1: A first byte whose upper seven bits equal `dev_addr_i` is acknowledged by SDA held low during the ninth clock. Any other address gets no acknowledge, and SDA stays released for the rest of that transfer until the next START.
- R2: The least significant bit of the address byte sets the direction: 0 selects a write, 1 selects a read.
- R3: In a write, the first byte after the address is a register index in the range 0 to NUM_REGS-1 and is acknowledged. Every later byte is stored at the current index and is acknowledged.
- R4: An index of NUM_REGS or above is not acknowledged. The target then ignores the bus until the next START and leaves every register unchanged.
- R5: The index advances by one after each data byte written or read, wrapping from NUM_REGS-1 to 0.
- R6: In a read, the target sends the register at the current index MSB first and releases SDA in the ninth clock. A master ACK (SDA low) moves on to the next register. A master NACK (SDA high) ends the read with SDA released.
- R7: A repeated START in the middle of a transfer restarts address decoding without passing through idle. The register index is kept across it and across complete transfers.
- R8: With SINGLE_REG set, the first byte after a write address goes straight into register 0, with no index phase. A read returns register 0.
- R9: A STOP (SDA rising while SCL is high) returns the target to idle with SDA released.
- R10: When `host_we_i` is high on a clock edge, `host_wdata_i` is stored at `host_addr_i`. `host_rdata_o` shows the register at `host_addr_i` combinationally. A bus write to the same register in the same cycle takes precedence.
- R11: After reset, all registers read zero and SDA is released. The SDA enable only changes while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock; oversamples the bus |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dev_addr_i | input | 7 | Device address this target answers |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe_o | output | 1 | High pulls SDA low (open-drain enable) |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | AW | Host register index, AW = clog2(NUM_REGS) |
| host_wdata_i | input | 8 | Host write data |
| host_rdata_o | output | 8 | Register contents at host_addr_i |

## Verification
The bench runs an ordinary indexed write of several bytes, and reads the stored values back through the host port to separate index capture from auto-increment. A combined write-then-read across a repeated START shows that the index survives. A burst that starts at the last register shows the wraparound. An out-of-range index and a foreign address are each followed by data bytes, which shows that the target really stays silent rather than only skipping one acknowledge. A second instance in single-register mode shares the same bus, so each transfer also confirms that the non-addressed target keeps the line released.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_PTR,
    ST_WR,
    ST_RD,
    ST_SKIP
  } tgt_state_e;
endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic prev_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] pipe_q;
  logic              prev_q;

  // idle bus is high, so reset to 1 to avoid a false edge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pipe_q <= '1;
      prev_q <= 1'b1;
    end else begin
      pipe_q <= {pipe_q[STAGES-2:0], line_i};
      prev_q <= pipe_q[STAGES-1];
    end
  end

  assign lvl_o  = pipe_q[STAGES-1];
  assign prev_o = prev_q;
  assign rise_o = lvl_o & ~prev_q;
  assign fall_o = ~lvl_o & prev_q;
endmodule

// File: rtl/i2c_tgt_regfile.sv
module i2c_tgt_regfile #(
  parameter int NUM_REGS = 16,
  parameter int AW       = 4
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            bus_we_i,
  input  logic [AW-1:0]                   bus_waddr_i,
  input  logic [i2c_tgt_pkg::BYTE_W-1:0]  bus_wdata_i,
  input  logic [AW-1:0]                   bus_raddr_i,
  output logic [i2c_tgt_pkg::BYTE_W-1:0]  bus_rdata_o,
  input  logic                            host_we_i,
  input  logic [AW-1:0]                   host_addr_i,
  input  logic [i2c_tgt_pkg::BYTE_W-1:0]  host_wdata_i,
  output logic [i2c_tgt_pkg::BYTE_W-1:0]  host_rdata_o
);
  import i2c_tgt_pkg::*;

  logic [BYTE_W-1:0] regs_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        regs_q[i] <= '0;
      end else if (bus_we_i && bus_waddr_i == AW'(i)) begin
        regs_q[i] <= bus_wdata_i;
      end else if (host_we_i && host_addr_i == AW'(i)) begin
        regs_q[i] <= host_wdata_i;
      end
    end
  end

  assign bus_rdata_o  = (int'(bus_raddr_i) < NUM_REGS) ? regs_q[bus_raddr_i] : '0;
  assign host_rdata_o = (int'(host_addr_i) < NUM_REGS) ? regs_q[host_addr_i] : '0;
endmodule

// File: rtl/i2c_tgt_engine.sv
module i2c_tgt_engine #(
  parameter int NUM_REGS   = 16,
  parameter bit SINGLE_REG = 1'b0,
  parameter int AW         = 4
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic [6:0]                     dev_addr_i,
  input  logic                           scl_rise_i,
  input  logic                           scl_fall_i,
  input  logic                           sda_lvl_i,
  input  logic                           start_i,
  input  logic                           stop_i,
  input  logic [i2c_tgt_pkg::BYTE_W-1:0] rd_data_i,
  output logic [AW-1:0]                  ptr_o,
  output logic                           wr_en_o,
  output logic [AW-1:0]                  wr_addr_o,
  output logic [i2c_tgt_pkg::BYTE_W-1:0] wr_data_o,
  output logic                           sda_oe_o,
  output i2c_tgt_pkg::tgt_state_e        state_o,
  output logic                           in_ack_o
);
  import i2c_tgt_pkg::*;

  tgt_state_e        st_q;
  logic [3:0]        bit_cnt_q;
  logic              in_ack_q;
  logic [BYTE_W-1:0] shreg_q;
  logic [BYTE_W-1:0] tx_q;
  logic [AW-1:0]     ptr_q;
  logic              rw_q;
  logic              mnack_q;
  logic              oe_q;
  logic              wr_en_q;
  logic [AW-1:0]     wr_addr_q;
  logic [BYTE_W-1:0] wr_data_q;
  logic [AW-1:0]     ptr_next;

  if (SINGLE_REG) begin : g_ptr_single
    assign ptr_next = '0;
  end else begin : g_ptr_multi
    assign ptr_next = (ptr_q == AW'(NUM_REGS - 1)) ? '0 : ptr_q + AW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      bit_cnt_q <= '0;
      in_ack_q  <= 1'b0;
      shreg_q   <= '0;
      tx_q      <= '0;
      ptr_q     <= '0;
      rw_q      <= 1'b0;
      mnack_q   <= 1'b1;
      oe_q      <= 1'b0;
      wr_en_q   <= 1'b0;
      wr_addr_q <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      if (start_i) begin
        st_q      <= ST_ADDR;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        oe_q      <= 1'b0;
      end else if (stop_i) begin
        st_q      <= ST_IDLE;
        bit_cnt_q <= '0;
        in_ack_q  <= 1'b0;
        oe_q      <= 1'b0;
      end else if (scl_rise_i) begin
        if (!in_ack_q && bit_cnt_q != 4'd8 &&
            (st_q == ST_ADDR || st_q == ST_PTR || st_q == ST_WR || st_q == ST_RD)) begin
          bit_cnt_q <= bit_cnt_q + 4'd1;
          if (st_q != ST_RD) shreg_q <= {shreg_q[BYTE_W-2:0], sda_lvl_i};
        end
        if (st_q == ST_RD && in_ack_q) mnack_q <= sda_lvl_i;
      end else if (scl_fall_i) begin
        case (st_q)
          ST_ADDR, ST_PTR, ST_WR: begin
            if (!in_ack_q) begin
              if (bit_cnt_q == 4'd8) begin
                // byte complete: decide ACK for the ninth clock
                unique case (st_q)
                  ST_ADDR: begin
                    if (shreg_q[7:1] == dev_addr_i) begin
                      in_ack_q <= 1'b1;
                      oe_q     <= 1'b1;
                      rw_q     <= shreg_q[0];
                    end else begin
                      st_q <= ST_SKIP;
                      oe_q <= 1'b0;
                    end
                  end
                  ST_PTR: begin
                    if (int'(shreg_q) < NUM_REGS) begin
                      in_ack_q <= 1'b1;
                      oe_q     <= 1'b1;
                      ptr_q    <= shreg_q[AW-1:0];
                    end else begin
                      st_q <= ST_SKIP;
                      oe_q <= 1'b0;
                    end
                  end
                  default: begin
                    in_ack_q  <= 1'b1;
                    oe_q      <= 1'b1;
                    wr_en_q   <= 1'b1;
                    wr_addr_q <= ptr_q;
                    wr_data_q <= shreg_q;
                    ptr_q     <= ptr_next;
                  end
                endcase
              end
            end else begin
              // end of ACK clock
              in_ack_q  <= 1'b0;
              bit_cnt_q <= '0;
              oe_q      <= 1'b0;
              if (st_q == ST_ADDR) begin
                if (rw_q) begin
                  st_q <= ST_RD;
                  tx_q <= rd_data_i;
                  oe_q <= ~rd_data_i[BYTE_W-1];
                end else begin
                  st_q <= SINGLE_REG ? ST_WR : ST_PTR;
                end
              end else begin
                st_q <= ST_WR;
              end
            end
          end
          ST_RD: begin
            if (!in_ack_q) begin
              if (bit_cnt_q == 4'd8) begin
                in_ack_q <= 1'b1;
                oe_q     <= 1'b0;
                ptr_q    <= ptr_next;
              end else begin
                oe_q <= ~tx_q[3'd7 - bit_cnt_q[2:0]];
              end
            end else begin
              in_ack_q  <= 1'b0;
              bit_cnt_q <= '0;
              if (mnack_q) begin
                st_q <= ST_SKIP;
                oe_q <= 1'b0;
              end else begin
                tx_q <= rd_data_i;
                oe_q <= ~rd_data_i[BYTE_W-1];
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign ptr_o     = ptr_q;
  assign wr_en_o   = wr_en_q;
  assign wr_addr_o = wr_addr_q;
  assign wr_data_o = wr_data_q;
  assign sda_oe_o  = oe_q;
  assign state_o   = st_q;
  assign in_ack_o  = in_ack_q;
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target #(
  parameter int NUM_REGS    = 16,
  parameter bit SINGLE_REG  = 1'b0,
  parameter int SYNC_STAGES = 2,
  localparam int AW = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [6:0]    dev_addr_i,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          sda_oe_o,
  input  logic          host_we_i,
  input  logic [AW-1:0] host_addr_i,
  input  logic [7:0]    host_wdata_i,
  output logic [7:0]    host_rdata_o
);
  import i2c_tgt_pkg::*;

  logic scl_lvl, scl_prev, scl_rise, scl_fall;
  logic sda_lvl, sda_prev, sda_rise, sda_fall;
  logic start_det, stop_det;
  logic [AW-1:0]     ptr;
  logic              bus_we;
  logic [AW-1:0]     bus_waddr;
  logic [BYTE_W-1:0] bus_wdata;
  logic [BYTE_W-1:0] bus_rdata;
  tgt_state_e        state;
  logic              in_ack;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_scl_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (scl_i),
    .lvl_o  (scl_lvl),
    .prev_o (scl_prev),
    .rise_o (scl_rise),
    .fall_o (scl_fall)
  );

  i2c_tgt_sync #(.STAGES(SYNC_STAGES)) u_sda_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .line_i (sda_i),
    .lvl_o  (sda_lvl),
    .prev_o (sda_prev),
    .rise_o (sda_rise),
    .fall_o (sda_fall)
  );

  assign start_det = scl_lvl & scl_prev & sda_fall;
  assign stop_det  = scl_lvl & scl_prev & sda_rise;

  i2c_tgt_engine #(
    .NUM_REGS   (NUM_REGS),
    .SINGLE_REG (SINGLE_REG),
    .AW         (AW)
  ) u_engine (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .dev_addr_i (dev_addr_i),
    .scl_rise_i (scl_rise),
    .scl_fall_i (scl_fall),
    .sda_lvl_i  (sda_lvl),
    .start_i    (start_det),
    .stop_i     (stop_det),
    .rd_data_i  (bus_rdata),
    .ptr_o      (ptr),
    .wr_en_o    (bus_we),
    .wr_addr_o  (bus_waddr),
    .wr_data_o  (bus_wdata),
    .sda_oe_o   (sda_oe_o),
    .state_o    (state),
    .in_ack_o   (in_ack)
  );

  i2c_tgt_regfile #(
    .NUM_REGS (NUM_REGS),
    .AW       (AW)
  ) u_regs (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .bus_we_i     (bus_we),
    .bus_waddr_i  (bus_waddr),
    .bus_wdata_i  (bus_wdata),
    .bus_raddr_i  (ptr),
    .bus_rdata_o  (bus_rdata),
    .host_we_i    (host_we_i),
    .host_addr_i  (host_addr_i),
    .host_wdata_i (host_wdata_i),
    .host_rdata_o (host_rdata_o)
  );
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk #(
  parameter int AW = 4
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    scl_lvl_i,
  input logic                    start_i,
  input logic                    stop_i,
  input i2c_tgt_pkg::tgt_state_e state_i,
  input logic                    in_ack_i,
  input logic                    sda_oe_i,
  input logic                    bus_we_i,
  input logic                    host_we_i,
  input logic [AW-1:0]           host_addr_i,
  input logic [7:0]              host_wdata_i,
  input logic [7:0]              host_rdata_i
);
  import i2c_tgt_pkg::*;

  AST_SILENT_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_IDLE || state_i == ST_SKIP) |-> !sda_oe_i); // R1

  AST_START_REDECODES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (state_i == ST_ADDR && !sda_oe_i)); // R7

  AST_STOP_IDLES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (state_i == ST_IDLE && !sda_oe_i)); // R9

  AST_MASTER_ACK_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_RD && in_ack_i) |-> !sda_oe_i); // R6

  AST_OE_SCL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_i) |-> !scl_lvl_i); // R11

  AST_HOST_WRITE_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (host_we_i && !bus_we_i) |=>
      (host_addr_i != $past(host_addr_i)) || (host_rdata_i == $past(host_wdata_i))); // R10
endmodule

bind i2c_reg_target i2c_reg_target_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .scl_lvl_i    (scl_lvl),
  .start_i      (start_det),
  .stop_i       (stop_det),
  .state_i      (state),
  .in_ack_i     (in_ack),
  .sda_oe_i     (sda_oe_o),
  .bus_we_i     (bus_we),
  .host_we_i    (host_we_i),
  .host_addr_i  (host_addr_i),
  .host_wdata_i (host_wdata_i),
  .host_rdata_i (host_rdata_o)
);

// File: tb/i2c_reg_target_test.sv
module i2c_reg_target_test;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 10;  // system clocks per quarter SCL period

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic scl_m = 1'b1;
  logic sda_m = 1'b1;
  logic sda_bus;
  logic oe_main, oe_single;
  assign sda_bus = sda_m & ~oe_main & ~oe_single;

  logic       m_we = 1'b0;
  logic [3:0] m_addr = '0;
  logic [7:0] m_wdata = '0;
  logic [7:0] m_rdata;
  logic       s_we = 1'b0;
  logic [0:0] s_addr = '0;
  logic [7:0] s_wdata = '0;
  logic [7:0] s_rdata;

  i2c_reg_target #(.NUM_REGS(16), .SINGLE_REG(1'b0)) uut (
    .clk_i(clk), .rst_ni(rst_n), .dev_addr_i(7'h50),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(oe_main),
    .host_we_i(m_we), .host_addr_i(m_addr), .host_wdata_i(m_wdata), .host_rdata_o(m_rdata)
  );

  i2c_reg_target #(.NUM_REGS(1), .SINGLE_REG(1'b1)) uut_single (
    .clk_i(clk), .rst_ni(rst_n), .dev_addr_i(7'h2A),
    .scl_i(scl_m), .sda_i(sda_bus), .sda_oe_o(oe_single),
    .host_we_i(s_we), .host_addr_i(s_addr), .host_wdata_i(s_wdata), .host_rdata_o(s_rdata)
  );

  int n_cmp = 0;
  int n_bad = 0;
  string      exp_t[$];
  logic [7:0] exp_v[$];
  logic [7:0] obs_v[$];

  // ack items are encoded as 8'h00 = ACK (SDA low), 8'h01 = NACK
  task automatic expect_v(input string tag, input logic [7:0] v);
    exp_t.push_back(tag);
    exp_v.push_back(v);
  endtask

  task automatic observe(input logic [7:0] v);
    obs_v.push_back(v);
  endtask

  initial begin : monitor
    forever begin
      @(negedge clk);
      while (obs_v.size() > 0 && exp_v.size() > 0) begin
        string      t;
        logic [7:0] e, a;
        t = exp_t.pop_front();
        e = exp_v.pop_front();
        a = obs_v.pop_front();
        n_cmp++;
        if (a !== e) begin
          n_bad++;
          $display("FAIL %s: actual %h expected %h", t, a, e);
        end
      end
    end
  end

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog R9: actual timeout expected completion");
    report();
    $finish;
  end

  task automatic qwait();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b0; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qwait();
    scl_m = 1'b1; qwait();
    sda_m = 1'b1; qwait();
  endtask

  task automatic send_bit(input logic b);
    sda_m = b; qwait();
    scl_m = 1'b1; qwait(); qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic recv_bit(output logic b);
    sda_m = 1'b1; qwait();
    scl_m = 1'b1; qwait();
    b = sda_bus; qwait();
    scl_m = 1'b0; qwait();
  endtask

  task automatic write_byte(input logic [7:0] d, output logic ack);
    for (int i = 7; i >= 0; i--) send_bit(d[i]);
    recv_bit(ack);
  endtask

  task automatic read_byte(input logic nack, output logic [7:0] d);
    for (int i = 7; i >= 0; i--) begin
      logic b;
      recv_bit(b);
      d[i] = b;
    end
    send_bit(nack);
  endtask

  task automatic wr_chk(input string tag, input logic [7:0] d, input logic exp_ack);
    logic a;
    expect_v(tag, {7'd0, exp_ack});
    write_byte(d, a);
    observe({7'd0, a});
  endtask

  task automatic rd_chk(input string tag, input logic nack, input logic [7:0] exp_d);
    logic [7:0] d;
    expect_v(tag, exp_d);
    read_byte(nack, d);
    observe(d);
  endtask

  task automatic host_chk(input string tag, input logic [3:0] a, input logic [7:0] exp_d);
    m_addr = a;
    @(negedge clk);
    expect_v(tag, exp_d);
    observe(m_rdata);
  endtask

  task automatic host_wr(input logic [3:0] a, input logic [7:0] d);
    m_addr = a; m_wdata = d; m_we = 1'b1;
    @(negedge clk);
    m_we = 1'b0;
  endtask

  task automatic oe_chk(input string tag);
    expect_v(tag, 8'h00);
    observe({6'd0, oe_single, oe_main});
  endtask

  initial begin : stimulus
    repeat (5) @(negedge clk);
    // R11: reset state
    oe_chk("R11 reset release");
    host_chk("R11 reset reg0", 4'd0, 8'h00);
    host_chk("R11 reset reg15", 4'd15, 8'h00);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 R3: indexed write of three bytes at index 3
    bus_start();
    wr_chk("R1 address ack", 8'hA0, 1'b0);
    wr_chk("R3 index ack", 8'h03, 1'b0);
    wr_chk("R3 data ack", 8'h11, 1'b0);
    wr_chk("R3 data ack", 8'h22, 1'b0);
    wr_chk("R3 data ack", 8'h33, 1'b0);
    bus_stop();
    oe_chk("R9 stop release");
    host_chk("R3 reg3", 4'd3, 8'h11);
    host_chk("R5 reg4", 4'd4, 8'h22);
    host_chk("R5 reg5", 4'd5, 8'h33);

    // R7 R6: combined write-then-read from index 4
    bus_start();
    wr_chk("R7 address ack", 8'hA0, 1'b0);
    wr_chk("R7 index ack", 8'h04, 1'b0);
    bus_start();
    wr_chk("R2 read address ack", 8'hA1, 1'b0);
    rd_chk("R7 first read", 1'b0, 8'h22);
    rd_chk("R6 second read after ACK", 1'b1, 8'h33);
    oe_chk("R6 released after NACK");
    bus_stop();

    // R5: wrap at last register
    bus_start();
    wr_chk("R5 address ack", 8'hA0, 1'b0);
    wr_chk("R5 index ack", 8'h0F, 1'b0);
    wr_chk("R5 data ack", 8'hAA, 1'b0);
    wr_chk("R5 data ack", 8'hBB, 1'b0);
    bus_stop();
    host_chk("R5 reg15", 4'd15, 8'hAA);
    host_chk("R5 wrap reg0", 4'd0, 8'hBB);

    // R4: unimplemented index
    bus_start();
    wr_chk("R4 address ack", 8'hA0, 1'b0);
    wr_chk("R4 bad index nack", 8'h20, 1'b1);
    wr_chk("R4 data ignored", 8'h00, 1'b1);
    bus_stop();
    host_chk("R4 reg0 unchanged", 4'd0, 8'hBB);

    // R1: foreign address
    bus_start();
    wr_chk("R1 mismatch nack", 8'hB0, 1'b1);
    wr_chk("R1 stays released", 8'h00, 1'b1);
    bus_stop();

    // R10: host writes then bus reads
    host_wr(4'd7, 8'h5C);
    host_wr(4'd8, 8'hC3);
    host_chk("R10 host reg7", 4'd7, 8'h5C);
    bus_start();
    wr_chk("R10 address ack", 8'hA0, 1'b0);
    wr_chk("R10 index ack", 8'h07, 1'b0);
    bus_start();
    wr_chk("R10 read address ack", 8'hA1, 1'b0);
    rd_chk("R10 bus sees host data", 1'b1, 8'h5C);
    bus_stop();

    // R2 R7: read-only transfer uses kept index (now 8)
    bus_start();
    wr_chk("R2 read address ack", 8'hA1, 1'b0);
    rd_chk("R2 read kept index", 1'b1, 8'hC3);
    bus_stop();

    // R8: single-register instance at 7'h2A
    bus_start();
    wr_chk("R8 address ack", 8'h54, 1'b0);
    wr_chk("R8 direct data ack", 8'h9E, 1'b0);
    bus_stop();
    s_addr = 1'b0;
    @(negedge clk);
    expect_v("R8 reg0 direct", 8'h9E);
    observe(s_rdata);
    host_chk("R8 other target untouched", 4'd0, 8'hBB);
    bus_start();
    wr_chk("R8 read address ack", 8'h55, 1'b0);
    rd_chk("R8 read reg0", 1'b1, 8'h9E);
    bus_stop();
    oe_chk("R9 final release");

    repeat (10) @(negedge clk);
    if (exp_v.size() != 0 || obs_v.size() != 0) begin
      n_bad++;
      $display("FAIL R9 scoreboard drain: actual %0d/%0d left expected 0/0",
               exp_v.size(), obs_v.size());
    end
    report();
    $finish;
  end
endmodule